// File: doc/BRIEF.md
# Code Byte Buffer with Quarter-Level Fullness Status

This block sits between an internal compression/decompression engine and an external code bus. It holds compressed code bytes in a circular byte store. When compressing, the engine pushes one byte per cycle and the bus side drains the buffer. When decompressing, the bus side fills the buffer and the engine pulls one byte per cycle. The request on the bus side is a single strobe, and the codec direction decides whether that strobe is a read or a write.

In slave mode the bus side can be 8 or 16 bits wide. In 16-bit mode each bus transfer moves two bytes, and an endian bit can exchange the two bytes of the word. In master mode the bus is always 8 bits wide, and the width and endian bits have no effect. A status byte gives the following:
- a 2-bit coarse fullness code taken from the registered occupancy;
- a busy flag for flow control, which is also driven on a dedicated pin;
- a pass-through bit that shows a parameter load is still in progress.

Top module: `code_buffer`

## Requirements
- R1: After reset the buffer is empty. The status byte has fullness code 00 and bit 7 equal to the load input. Busy is 0 in compression mode and 1 in decompression mode.
- R2: In 8-bit mode, bytes leave the buffer in the order they were accepted, whichever side writes.
- R3: Status bits 1:0 encode the registered occupancy n of a DEPTH-byte buffer: 00 when n < DEPTH/4, 01 when DEPTH/4 <= n < DEPTH/2, 10 when DEPTH/2 <= n < 3·DEPTH/4, and 11 when n >= 3·DEPTH/4.
- R4: Status bit 2 and the busy pin carry the same value. In compression mode (cfg_compress=1) that value is 1 exactly when the buffer is full. In decompression mode it is 1 exactly when the buffer is empty.
- R5: Status bit 7 follows load_busy_in, and status bits 6:3 read as zero.
- R6: Slave 16-bit mode is cfg_master=0 and cfg_code16=1. With endian 0 in this mode, each bus transfer moves two bytes, and the earlier byte in buffer order travels on bits 7:0.
- R7: In slave 16-bit mode with endian 1, the earlier byte travels on bits 15:8 instead.
- R8: Master mode (cfg_master=1) uses an 8-bit bus whatever the values of cfg_code16 and cfg_endian. Data travels on bits 7:0, and bus_rdata bits 15:8 read as zero.
- R9: A push is refused if there is not enough free space for all of its bytes. A pop is refused if the buffer holds fewer bytes than one transfer needs. A refused transfer drops its ack and leaves the occupancy unchanged.
- R10: When a one-byte push and a one-byte pop are both accepted in the same cycle, the occupancy is unchanged.
- R11: In compression mode only the engine can write and only the bus can read. In decompression mode only the bus can write and only the engine can read. A request on the inactive path is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_compress | input | 1 | 1 = compression direction, 0 = decompression |
| cfg_code16 | input | 1 | 16-bit bus select (slave mode only) |
| cfg_endian | input | 1 | Byte exchange for 16-bit slave transfers |
| cfg_master | input | 1 | 1 = bus master mode (8-bit), 0 = slave |
| load_busy_in | input | 1 | Parameter load in progress |
| eng_wr_valid | input | 1 | Engine push request |
| eng_wr_data | input | 8 | Engine push byte |
| eng_wr_ok | output | 1 | Engine push accepted this cycle |
| eng_rd_req | input | 1 | Engine pop request |
| eng_rd_data | output | 8 | Byte at the head of the buffer |
| eng_rd_ok | output | 1 | Engine pop accepted this cycle |
| bus_req | input | 1 | Bus-side transfer strobe |
| bus_wdata | input | 16 | Bus write word |
| bus_rdata | output | 16 | Bus read word |
| bus_ack | output | 1 | Bus transfer accepted this cycle |
| status | output | 8 | Read-only status byte |
| busy_pin | output | 1 | Flow-control busy output |

## Verification
The random phases switch between long stretches of heavy writing and heavy reading. This drives the occupancy through every quarter boundary and into both full and empty, so all four fullness codes and both busy conditions are exercised. Each bus format runs as a separate phase, so a wrong byte order or a wrong transfer width gives a different data word or an off-by-one occupancy: 8-bit slave decompression, master with the width and endian bits set, 16-bit slave with each endian, and both directions. A directed sequence loads a few bytes, issues same-cycle push and pop, and then counts the bytes that can be drained. This shows whether simultaneous transfers leave the occupancy unchanged. Another directed run fills the buffer and checks that further pushes are refused.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    typedef struct packed {
        logic wide;   // two bytes per bus transfer
        logic swap;   // earlier byte on the upper half
    } bus_fmt_t;

    function automatic bus_fmt_t decode_fmt(input logic code16,
                                            input logic endian,
                                            input logic master);
        bus_fmt_t f;
        f.wide = code16 & ~master;
        f.swap = code16 & ~master & endian;
        return f;
    endfunction

endpackage

// File: rtl/cbuf_store.sv
module cbuf_store #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_cnt,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic [1:0]    pop_cnt,
    output logic [7:0]    head0,
    output logic [7:0]    head1,
    output logic [CW-1:0] occ
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [7:0] mem_q [DEPTH];
    logic [PW-1:0] wr_nx, rd_nx;

    always_comb begin
        st_d     = st_q;
        st_d.wr  = st_q.wr + PW'(push_cnt);
        st_d.rd  = st_q.rd + PW'(pop_cnt);
        st_d.cnt = st_q.cnt + CW'(push_cnt) - CW'(pop_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_nx = st_q.wr + PW'(1);
    assign rd_nx = st_q.rd + PW'(1);

    always_ff @(posedge clk) begin
        if (push_cnt != 2'd0) mem_q[st_q.wr] <= push_b0;
        if (push_cnt == 2'd2) mem_q[wr_nx]   <= push_b1;
    end

    assign head0 = mem_q[st_q.rd];
    assign head1 = mem_q[rd_nx];
    assign occ   = st_q.cnt;

endmodule

// File: rtl/cbuf_port.sv
module cbuf_port
    import cbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          cfg_compress,
    input  logic          cfg_code16,
    input  logic          cfg_endian,
    input  logic          cfg_master,
    input  logic          eng_wr_valid,
    input  logic [7:0]    eng_wr_data,
    input  logic          eng_rd_req,
    input  logic          bus_req,
    input  logic [15:0]   bus_wdata,
    input  logic [CW-1:0] occ,
    input  logic [7:0]    head0,
    input  logic [7:0]    head1,
    output logic          eng_wr_ok,
    output logic          eng_rd_ok,
    output logic          bus_ack,
    output logic [1:0]    push_cnt,
    output logic [1:0]    pop_cnt,
    output logic [7:0]    push_b0,
    output logic [7:0]    push_b1,
    output logic [15:0]   bus_rdata,
    output logic [7:0]    eng_rd_data
);

    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    bus_fmt_t      fmt;
    logic [CW-1:0] unit;
    logic [CW-1:0] room;

    always_comb begin
        fmt  = decode_fmt(cfg_code16, cfg_endian, cfg_master);
        unit = fmt.wide ? CW'(2) : CW'(1);
        room = CAP - occ;

        eng_wr_ok   = 1'b0;
        eng_rd_ok   = 1'b0;
        bus_ack     = 1'b0;
        push_cnt    = 2'd0;
        pop_cnt     = 2'd0;
        push_b0     = 8'h00;
        push_b1     = 8'h00;
        bus_rdata   = 16'h0000;
        eng_rd_data = head0;

        if (cfg_compress) begin
            eng_wr_ok = eng_wr_valid && (room != '0);
            bus_ack   = bus_req && (occ >= unit);
            push_b0   = eng_wr_data;
            push_cnt  = eng_wr_ok ? 2'd1 : 2'd0;
            if (bus_ack) pop_cnt = fmt.wide ? 2'd2 : 2'd1;
            if (!fmt.wide)     bus_rdata = {8'h00, head0};
            else if (fmt.swap) bus_rdata = {head0, head1};
            else               bus_rdata = {head1, head0};
        end else begin
            bus_ack   = bus_req && (room >= unit);
            eng_rd_ok = eng_rd_req && (occ != '0);
            pop_cnt   = eng_rd_ok ? 2'd1 : 2'd0;
            if (bus_ack) push_cnt = fmt.wide ? 2'd2 : 2'd1;
            push_b0 = fmt.swap ? bus_wdata[15:8] : bus_wdata[7:0];
            push_b1 = fmt.swap ? bus_wdata[7:0]  : bus_wdata[15:8];
        end
    end

endmodule

// File: rtl/cbuf_status.sv
module cbuf_status #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          cfg_compress,
    input  logic          load_busy_in,
    input  logic [CW-1:0] occ,
    output logic [7:0]    status,
    output logic          busy
);

    localparam logic [CW-1:0] Q1  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] Q2  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] Q3  = CW'((3 * DEPTH) / 4);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [1:0] fill;

    always_comb begin
        if (occ >= Q3)      fill = 2'b11;
        else if (occ >= Q2) fill = 2'b10;
        else if (occ >= Q1) fill = 2'b01;
        else                fill = 2'b00;
        busy   = cfg_compress ? (occ == CAP) : (occ == '0);
        status = {load_busy_in, 4'b0000, busy, fill};
    end

endmodule

// File: rtl/code_buffer.sv
module code_buffer #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_compress,
    input  logic        cfg_code16,
    input  logic        cfg_endian,
    input  logic        cfg_master,
    input  logic        load_busy_in,
    input  logic        eng_wr_valid,
    input  logic [7:0]  eng_wr_data,
    output logic        eng_wr_ok,
    input  logic        eng_rd_req,
    output logic [7:0]  eng_rd_data,
    output logic        eng_rd_ok,
    input  logic        bus_req,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_ack,
    output logic [7:0]  status,
    output logic        busy_pin
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic [1:0]    push_cnt, pop_cnt;
    logic [7:0]    push_b0, push_b1, head0, head1;
    logic [CW-1:0] occ_q;

    cbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_cnt (push_cnt),
        .push_b0  (push_b0),
        .push_b1  (push_b1),
        .pop_cnt  (pop_cnt),
        .head0    (head0),
        .head1    (head1),
        .occ      (occ_q)
    );

    cbuf_port #(.DEPTH(DEPTH)) u_port (
        .cfg_compress (cfg_compress),
        .cfg_code16   (cfg_code16),
        .cfg_endian   (cfg_endian),
        .cfg_master   (cfg_master),
        .eng_wr_valid (eng_wr_valid),
        .eng_wr_data  (eng_wr_data),
        .eng_rd_req   (eng_rd_req),
        .bus_req      (bus_req),
        .bus_wdata    (bus_wdata),
        .occ          (occ_q),
        .head0        (head0),
        .head1        (head1),
        .eng_wr_ok    (eng_wr_ok),
        .eng_rd_ok    (eng_rd_ok),
        .bus_ack      (bus_ack),
        .push_cnt     (push_cnt),
        .pop_cnt      (pop_cnt),
        .push_b0      (push_b0),
        .push_b1      (push_b1),
        .bus_rdata    (bus_rdata),
        .eng_rd_data  (eng_rd_data)
    );

    cbuf_status #(.DEPTH(DEPTH)) u_status (
        .cfg_compress (cfg_compress),
        .load_busy_in (load_busy_in),
        .occ          (occ_q),
        .status       (status),
        .busy         (busy_pin)
    );

endmodule

// File: rtl/cbuf_checker.sv
module cbuf_checker #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_compress,
    input logic          cfg_code16,
    input logic          cfg_master,
    input logic [CW-1:0] occ,
    input logic [7:0]    status,
    input logic          busy_pin,
    input logic          eng_wr_ok,
    input logic          bus_ack
);

    localparam logic [CW-1:0] CAP = CW'(DEPTH);
    localparam logic [CW-1:0] Q1  = CW'(DEPTH / 4);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CAP);  // R9
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_compress && occ == CAP) |-> !eng_wr_ok);  // R9
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_compress |-> (busy_pin == (occ == CAP)));  // R4
    AST_BUSY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_compress |-> (busy_pin == (occ == '0)));  // R4
    AST_FILL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CAP) |-> (status[1:0] == 2'b11));  // R3
    AST_FILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < Q1) |-> (status[1:0] == 2'b00));  // R3
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:3] == 4'b0000);  // R5
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_compress && eng_wr_ok && bus_ack && (cfg_master || !cfg_code16))
        |=> (occ == $past(occ)));  // R10

endmodule

bind code_buffer cbuf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_compress (cfg_compress),
    .cfg_code16   (cfg_code16),
    .cfg_master   (cfg_master),
    .occ          (occ_q),
    .status       (status),
    .busy_pin     (busy_pin),
    .eng_wr_ok    (eng_wr_ok),
    .bus_ack      (bus_ack)
);

// File: tb/code_buffer_tb.sv
module code_buffer_tb;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_compress, cfg_code16, cfg_endian, cfg_master, load_busy_in;
    logic eng_wr_valid, eng_rd_req, bus_req;
    logic [7:0]  eng_wr_data;
    logic [15:0] bus_wdata;
    logic eng_wr_ok, eng_rd_ok, bus_ack, busy_pin;
    logic [7:0]  eng_rd_data, status;
    logic [15:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] q[$];

    always #2 clk = ~clk;

    code_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_compress(cfg_compress),
        .cfg_code16(cfg_code16), .cfg_endian(cfg_endian), .cfg_master(cfg_master),
        .load_busy_in(load_busy_in), .eng_wr_valid(eng_wr_valid),
        .eng_wr_data(eng_wr_data), .eng_wr_ok(eng_wr_ok), .eng_rd_req(eng_rd_req),
        .eng_rd_data(eng_rd_data), .eng_rd_ok(eng_rd_ok), .bus_req(bus_req),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .status(status), .busy_pin(busy_pin)
    );

    function automatic logic [1:0] exp_fill(input int n);
        if (4 * n >= 3 * DEPTH) return 2'b11;
        if (2 * n >= DEPTH)     return 2'b10;
        if (4 * n >= DEPTH)     return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic idle;
        eng_wr_valid = 0; eng_rd_req = 0; bus_req = 0;
        eng_wr_data = 0; bus_wdata = 0; load_busy_in = 0;
    endtask

    task automatic do_reset(input bit comp, input bit c16, input bit endn, input bit mst);
        @(negedge clk);
        rst_n = 0; idle();
        cfg_compress = comp; cfg_code16 = c16; cfg_endian = endn; cfg_master = mst;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        q.delete();
        #1;
        chk("R1 status after reset", {8'h00, status}, {8'h00, 5'b00000, ~comp, 2'b00});
        chk("R1 busy pin after reset", {15'h0, busy_pin}, {15'h0, ~comp});
    endtask

    // one cycle: drive at negedge, check combinational outputs, then take the edge
    task automatic step(input bit ew, input logic [7:0] ewd, input bit er,
                        input bit br, input logic [15:0] bwd, input bit ld);
        int  sz, n;
        bit  wide, swap, ewok, erok, bok;
        logic [7:0] b0, b1;
        logic [15:0] rexp;
        string dtag;
        @(negedge clk);
        eng_wr_valid = ew; eng_wr_data = ewd; eng_rd_req = er;
        bus_req = br; bus_wdata = bwd; load_busy_in = ld;
        #1;
        sz   = q.size();
        wide = cfg_code16 && !cfg_master;
        swap = wide && cfg_endian;
        n    = wide ? 2 : 1;
        if (swap)                         dtag = "R7";
        else if (wide)                    dtag = "R6";
        else if (cfg_master && cfg_code16) dtag = "R8";
        else                              dtag = "R2";

        chk("R3 fill code", {14'h0, status[1:0]}, {14'h0, exp_fill(sz)});
        chk("R4 busy flag", {15'h0, status[2]},
            {15'h0, cfg_compress ? (sz == DEPTH) : (sz == 0)});
        chk("R4 busy pin", {15'h0, busy_pin}, {15'h0, status[2]});
        chk("R5 load bit and pad", {11'h0, status[7:3]}, {11'h0, ld, 4'b0000});

        if (cfg_compress) begin
            ewok = ew && (sz < DEPTH);
            bok  = br && (sz >= n);
            erok = 0;
        end else begin
            ewok = 0;
            bok  = br && (sz <= DEPTH - n);
            erok = er && (sz >= 1);
        end
        chk((ew && !ewok && cfg_compress) ? "R9 engine push refusal" : "R11 engine push ack",
            {15'h0, eng_wr_ok}, {15'h0, ewok});
        chk((br && !bok) ? "R9 bus refusal" : "R11 bus ack", {15'h0, bus_ack}, {15'h0, bok});
        chk((er && !erok && !cfg_compress) ? "R9 engine pop refusal" : "R11 engine pop ack",
            {15'h0, eng_rd_ok}, {15'h0, erok});

        if (cfg_compress) begin
            if (bok) begin
                b0 = q[0];
                b1 = wide ? q[1] : 8'h00;
                rexp = !wide ? {8'h00, b0} : (swap ? {b0, b1} : {b1, b0});
                chk({dtag, " bus read word"}, bus_rdata, rexp);
                repeat (n) void'(q.pop_front());
            end
            if (ewok) q.push_back(ewd);
        end else begin
            if (erok) begin
                chk({dtag, " engine read byte"}, {8'h00, eng_rd_data}, {8'h00, q[0]});
                void'(q.pop_front());
            end
            if (bok) begin
                if (!wide)     q.push_back(bwd[7:0]);
                else if (swap) begin q.push_back(bwd[15:8]); q.push_back(bwd[7:0]); end
                else           begin q.push_back(bwd[7:0]);  q.push_back(bwd[15:8]); end
            end
        end
        @(posedge clk);
    endtask

    task automatic rand_phase(input bit comp, input bit c16, input bit endn,
                              input bit mst, input int ncyc);
        do_reset(comp, c16, endn, mst);
        for (int i = 0; i < ncyc; i++) begin
            bit fillhard = ((i / 40) % 2) == 0;
            int pw = fillhard ? 85 : 20;
            int pr = fillhard ? 20 : 85;
            bit wr = ($urandom % 100) < pw;
            bit rd = ($urandom % 100) < pr;
            if (comp)
                step(wr, 8'($urandom), 1'b0, rd, 16'($urandom), 1'($urandom));
            else
                step(1'b0, 8'($urandom), rd, wr, 16'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int drained;
        void'($urandom(32'd4242));
        rst_n = 0; idle();
        cfg_compress = 1; cfg_code16 = 0; cfg_endian = 0; cfg_master = 1;

        // directed: fill to full in 8-bit compression, then try one more push
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h40 + i), 1'b0, 1'b0, 16'h0, 1'b0);
        step(1'b1, 8'hEE, 1'b0, 1'b0, 16'h0, 1'b1);   // R9 refused at full, R4 busy
        for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h0, 1'b0, 1'b1, 16'h0, 1'b0); // R2 order
        step(1'b0, 8'h0, 1'b0, 1'b1, 16'h0, 1'b0);    // R9 pop on empty

        // directed R10: five bytes, three same-cycle push+pop, then drain and count
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 16'h0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 8'(8'h80 + i), 1'b0, 1'b1, 16'h0, 1'b0);
        drained = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            idle(); bus_req = 1; #1;
            if (bus_ack) drained++;
            @(posedge clk);
        end
        @(negedge clk); idle();
        chk("R10 occupancy after same-cycle push and pop", 16'(drained), 16'd5);

        // directed R11: wrong-direction requests in decompression with data present
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h0, 1'b0, 1'b1, 16'h00A5, 1'b0);
        step(1'b1, 8'h33, 1'b0, 1'b0, 16'h0, 1'b0);    // engine write ignored
        step(1'b0, 8'h0, 1'b1, 1'b0, 16'h0, 1'b0);     // reads A5, buffer now empty

        rand_phase(1'b1, 1'b1, 1'b1, 1'b1, 400);  // R8 master ignores width/endian
        rand_phase(1'b1, 1'b1, 1'b0, 1'b0, 400);  // R6
        rand_phase(1'b0, 1'b1, 1'b1, 1'b0, 400);  // R7
        rand_phase(1'b0, 1'b0, 1'b1, 1'b0, 400);  // R2 8-bit slave decompression
        rand_phase(1'b1, 1'b1, 1'b1, 1'b0, 400);  // R7 compression side

        finish_run();
    end

endmodule